// File: doc/BRIEF.md
# Watchdog Timer with Two-Write Service Sequence

This block is a watchdog that counts down in a dedicated watchdog clock domain and is configured and serviced from a simple register bus in the bus clock domain. Software sets a reload value and enables the watchdog. It must then service the watchdog regularly by writing 0xAA and then 0x55 to the service register as two back-to-back accesses. If the counter reaches its end first, the block raises a timeout flag and an interrupt, and it can also drive a reset request. A broken service sequence counts as a service error. While the watchdog runs, a service error is handled the same way as an expiry.

A divide-by-four prescaler on the watchdog clock steps the 24-bit counter. The enable bit is held in a shadow stage until the first valid service sequence, so counting starts only once software has serviced the block at least once. The enable and reset-enable bits can only be set; only a system reset clears them. A free-running handshake copies the live count into the bus domain. A read of the count register therefore returns a value that lags the counter by a bounded amount.

There are two state machines in the bus domain. The service sequencer has the states FEED_IDLE and FEED_ARMED:
- A 0xAA write to the service register moves it from FEED_IDLE to FEED_ARMED (arm).
- In FEED_ARMED, a 0x55 write to the service register returns it to FEED_IDLE with a valid service (accept).
- In FEED_ARMED, any other access returns it to FEED_IDLE with a service error (abort).

The count capture machine has the states SNAP_LAUNCH and SNAP_WAIT:
- SNAP_LAUNCH flips the request toggle and moves to SNAP_WAIT (launch).
- SNAP_WAIT returns to SNAP_LAUNCH once the acknowledge toggle comes back, loading the captured count as it goes (land).

Top module: `wdt_feed_guard`

## Requirements
- R1: After reset, the control register (offset 0) reads 0, the reload register (offset 1) reads 0x0000_00FF, the count register (offset 3) reads 0x0000_00FF, and both wd_irq_o and wd_reset_o are low.
- R2: A write to the reload register keeps bits 23:0 of the data. If that value is below 0xFF, 0xFF is stored instead. Reads return the stored value with bits 31:24 at zero.
- R3: A write of 0xAA to the service register (offset 2), followed by a write of 0x55 to it as the very next bus access, is a valid service. It loads the counter with the reload value.
- R4: Any other access between the 0xAA write and the next access aborts the sequence as a service error, and the counter is not reloaded. Such an access is a read, a write to another offset, or a service write other than 0x55. While the watchdog runs, a service error sets the timeout flag (control bit 2) and, if reset-enable is set, drives wd_reset_o high. It does not set the interrupt flag.
- R5: Setting enable (control bit 0) does not start counting until a valid service sequence has completed while enable is set.
- R6: Writes cannot clear enable (bit 0) or reset-enable (bit 1); only rst_n clears them.
- R7: While running, the counter steps down once every 4 watchdog clocks. From a reload value N it expires after (N+1)*4 watchdog clocks. Expiry sets the timeout flag (bit 2) and the interrupt flag (bit 3), drives wd_irq_o high, reloads the counter and keeps counting.
- R8: An expiry with reset-enable set drives wd_reset_o high. wd_reset_o then stays high until rst_n.
- R9: Writing 0 to control bit 2 clears the timeout flag. Writing 1 to it has no effect.
- R10: A valid service clears the interrupt flag and wd_irq_o.
- R11: The count register returns the live counter with bits 31:24 at zero. It lags by at most about 6 watchdog clocks plus 6 bus clocks.
- R12: The service register uses only bits 7:0 of the write data. Bits 31:8 are ignored when the sequence is matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus (register) clock |
| wd_clk | input | 1 | Watchdog counter clock |
| rst_n | input | 1 | Asynchronous active-low system reset, both domains |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset: 0 control, 1 reload, 2 service, 3 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| wd_irq_o | output | 1 | Expiry interrupt, level |
| wd_reset_o | output | 1 | Reset request, sticky until rst_n |

## Verification
The bench aborts the service sequence in two ways: with a read in the middle, and with a wrong byte written to the service register. It then checks that the trailing 0x55 reloads nothing. A design that accepted a late 0x55 would show the count jumping back up. A design that ignored interposed reads would leave the timeout flag clear. The bench also services with upper data bits set, tries to clear the enable and reset-enable bits and to set the timeout flag by writing, and confirms the counter stays frozen when enable is set but no service has happened. A design without the shadow stage would start counting early. A design with a wrong prescaler or lost crossings would expire outside the checked window or read back a count out of range. The sticky reset is checked across a later valid service.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_FEED   = 2'd2,
        REG_COUNT  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        FEED_IDLE,
        FEED_ARMED
    } feed_st_e;

    typedef enum logic {
        SNAP_LAUNCH,
        SNAP_WAIT
    } snap_st_e;

    localparam int CTRL_EN  = 0;
    localparam int CTRL_RST = 1;
    localparam int CTRL_TOF = 2;
    localparam int CTRL_INT = 3;

    localparam logic [7:0] FEED_KEY_A = 8'hAA;
    localparam logic [7:0] FEED_KEY_B = 8'h55;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wdt_feed_fsm.sv
module wdt_feed_fsm
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  logic       wr,
    input  logic [1:0] addr,
    input  logic [7:0] key,
    output logic       feed_ok,
    output logic       feed_err
);
    feed_st_e state, state_nx;
    logic     key_hit_a, key_hit_b;

    assign key_hit_a = acc && wr && (reg_sel_e'(addr) == REG_FEED) && (key == FEED_KEY_A);
    assign key_hit_b = acc && wr && (reg_sel_e'(addr) == REG_FEED) && (key == FEED_KEY_B);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= FEED_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        feed_ok  = 1'b0;
        feed_err = 1'b0;
        unique case (state)
            FEED_IDLE: begin
                if (key_hit_a) state_nx = FEED_ARMED;
            end
            FEED_ARMED: begin
                if (acc) begin
                    state_nx = FEED_IDLE;
                    feed_ok  = key_hit_b;
                    feed_err = !key_hit_b;
                end
            end
        endcase
    end
endmodule

// File: rtl/wdt_snap_fsm.sv
module wdt_snap_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_s,
    output logic req_tgl,
    output logic land
);
    snap_st_e state, state_nx;
    logic     launch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SNAP_LAUNCH;
            req_tgl <= 1'b0;
        end else begin
            state <= state_nx;
            if (launch) req_tgl <= !req_tgl;
        end
    end

    always_comb begin
        state_nx = state;
        launch   = 1'b0;
        land     = 1'b0;
        unique case (state)
            SNAP_LAUNCH: begin
                launch   = 1'b1;
                state_nx = SNAP_WAIT;
            end
            SNAP_WAIT: begin
                if (ack_s == req_tgl) begin
                    land     = 1'b1;
                    state_nx = SNAP_LAUNCH;
                end
            end
        endcase
    end
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
    parameter int CNT_W    = 24,
    parameter int PRESCALE = 4,
    parameter int SYNC_N   = 2,
    parameter int RST_VAL  = 255
) (
    input  logic             wd_clk,
    input  logic             rst_n,
    input  logic             run_a,
    input  logic             feed_tgl_a,
    input  logic [CNT_W-1:0] feed_val_a,
    input  logic             req_tgl_a,
    output logic [CNT_W-1:0] snap_q,
    output logic             ack_tgl,
    output logic             uf_tgl
);
    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic             run_s, feed_s, feed_prev, req_s;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic             feed_edge, tick;

    wdt_sync #(.STAGES(SYNC_N)) u_sync_run  (.clk(wd_clk), .rst_n(rst_n), .d(run_a),      .q(run_s));
    wdt_sync #(.STAGES(SYNC_N)) u_sync_feed (.clk(wd_clk), .rst_n(rst_n), .d(feed_tgl_a), .q(feed_s));
    wdt_sync #(.STAGES(SYNC_N)) u_sync_req  (.clk(wd_clk), .rst_n(rst_n), .d(req_tgl_a),  .q(req_s));

    assign feed_edge = feed_s ^ feed_prev;
    assign tick      = run_s && (pre_q == PRE_LAST);

    always_ff @(posedge wd_clk or negedge rst_n) begin
        if (!rst_n) begin
            feed_prev <= 1'b0;
            pre_q     <= '0;
            cnt_q     <= CNT_W'(RST_VAL);
            uf_tgl    <= 1'b0;
        end else begin
            feed_prev <= feed_s;
            if (feed_edge) begin
                cnt_q <= feed_val_a;
                pre_q <= '0;
            end else if (run_s) begin
                pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
                if (tick) begin
                    if (cnt_q == '0) begin
                        cnt_q  <= feed_val_a;
                        uf_tgl <= !uf_tgl;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge wd_clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q  <= CNT_W'(RST_VAL);
            ack_tgl <= 1'b0;
        end else if (req_s != ack_tgl) begin
            snap_q  <= cnt_q;
            ack_tgl <= req_s;
        end
    end
endmodule

// File: rtl/wdt_feed_guard.sv
module wdt_feed_guard
    import wdt_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 24,
    parameter int PRESCALE   = 4,
    parameter int SYNC_N     = 2,
    parameter int MIN_RELOAD = 255
) (
    input  logic              bus_clk,
    input  logic              wd_clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wd_irq_o,
    output logic              wd_reset_o
);
    localparam logic [CNT_W-1:0] RELOAD_FLOOR = CNT_W'(MIN_RELOAD);
    localparam int PAD_W = DATA_W - CNT_W;

    logic             mode_en, mode_rsten, mode_tof, mode_int;
    logic             en_active;
    logic [CNT_W-1:0] reload_q, feed_val_q, cnt_shadow;
    logic             feed_tgl_q;
    logic             feed_ok, feed_err;
    logic             req_tgl, land, ack_tgl, ack_s;
    logic             uf_tgl, uf_s, uf_prev, uf_evt;
    logic [CNT_W-1:0] snap_q;
    logic             wr_ctrl, wr_reload;
    logic [CNT_W-1:0] wr_val;
    logic             unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:CNT_W];
    assign wr_ctrl   = bus_sel && bus_wr && (reg_sel_e'(bus_addr) == REG_CTRL);
    assign wr_reload = bus_sel && bus_wr && (reg_sel_e'(bus_addr) == REG_RELOAD);
    assign wr_val    = bus_wdata[CNT_W-1:0];

    wdt_feed_fsm u_feed (
        .clk(bus_clk), .rst_n(rst_n), .acc(bus_sel), .wr(bus_wr),
        .addr(bus_addr), .key(bus_wdata[7:0]),
        .feed_ok(feed_ok), .feed_err(feed_err)
    );

    wdt_snap_fsm u_snap (
        .clk(bus_clk), .rst_n(rst_n), .ack_s(ack_s),
        .req_tgl(req_tgl), .land(land)
    );

    wdt_count_core #(
        .CNT_W(CNT_W), .PRESCALE(PRESCALE), .SYNC_N(SYNC_N), .RST_VAL(MIN_RELOAD)
    ) u_core (
        .wd_clk(wd_clk), .rst_n(rst_n), .run_a(en_active),
        .feed_tgl_a(feed_tgl_q), .feed_val_a(feed_val_q), .req_tgl_a(req_tgl),
        .snap_q(snap_q), .ack_tgl(ack_tgl), .uf_tgl(uf_tgl)
    );

    wdt_sync #(.STAGES(SYNC_N)) u_sync_ack (.clk(bus_clk), .rst_n(rst_n), .d(ack_tgl), .q(ack_s));
    wdt_sync #(.STAGES(SYNC_N)) u_sync_uf  (.clk(bus_clk), .rst_n(rst_n), .d(uf_tgl),  .q(uf_s));

    assign uf_evt = uf_s ^ uf_prev;

    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_en    <= 1'b0;
            mode_rsten <= 1'b0;
            mode_tof   <= 1'b0;
            mode_int   <= 1'b0;
            en_active  <= 1'b0;
            wd_reset_o <= 1'b0;
            reload_q   <= RELOAD_FLOOR;
            feed_val_q <= RELOAD_FLOOR;
            feed_tgl_q <= 1'b0;
            cnt_shadow <= RELOAD_FLOOR;
            uf_prev    <= 1'b0;
        end else begin
            uf_prev <= uf_s;
            if (land) cnt_shadow <= snap_q;
            if (wr_reload) reload_q <= (wr_val < RELOAD_FLOOR) ? RELOAD_FLOOR : wr_val;
            if (wr_ctrl) begin
                if (bus_wdata[CTRL_EN])   mode_en    <= 1'b1;
                if (bus_wdata[CTRL_RST])  mode_rsten <= 1'b1;
                if (!bus_wdata[CTRL_TOF]) mode_tof   <= 1'b0;
            end
            if (feed_ok) begin
                feed_val_q <= reload_q;
                feed_tgl_q <= !feed_tgl_q;
                mode_int   <= 1'b0;
                if (mode_en) en_active <= 1'b1;
            end
            if (feed_err && en_active) begin
                mode_tof <= 1'b1;
                if (mode_rsten) wd_reset_o <= 1'b1;
            end
            if (uf_evt) begin
                mode_tof <= 1'b1;
                mode_int <= 1'b1;
                if (mode_rsten) wd_reset_o <= 1'b1;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (reg_sel_e'(bus_addr))
            REG_CTRL: begin
                bus_rdata[CTRL_EN]  = mode_en;
                bus_rdata[CTRL_RST] = mode_rsten;
                bus_rdata[CTRL_TOF] = mode_tof;
                bus_rdata[CTRL_INT] = mode_int;
            end
            REG_RELOAD: bus_rdata = {{PAD_W{1'b0}}, reload_q};
            REG_FEED:   bus_rdata = '0;
            REG_COUNT:  bus_rdata = {{PAD_W{1'b0}}, cnt_shadow};
        endcase
    end

    assign wd_irq_o = mode_int;
endmodule

// File: rtl/wdt_feed_guard_chk.sv
module wdt_feed_guard_chk #(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 24,
    parameter int MIN_RELOAD = 255
) (
    input logic              bus_clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              feed_ok,
    input logic              feed_err,
    input logic              en_active,
    input logic              mode_en,
    input logic              mode_rsten,
    input logic              mode_tof,
    input logic              uf_evt,
    input logic [CNT_W-1:0]  reload_q,
    input logic              wd_irq_o,
    input logic              wd_reset_o
);
    p_reload_floor_r2: assert property (@(posedge bus_clk) disable iff (!rst_n)
        reload_q >= CNT_W'(MIN_RELOAD));

    p_feed_exclusive_r4: assert property (@(posedge bus_clk) disable iff (!rst_n)
        !(feed_ok && feed_err));

    p_err_reset_r4: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (feed_err && en_active && mode_rsten) |=> wd_reset_o);

    p_start_after_feed_r5: assert property (@(posedge bus_clk) disable iff (!rst_n)
        $rose(en_active) |-> $past(feed_ok));

    p_en_sticky_r6: assert property (@(posedge bus_clk) disable iff (!rst_n)
        mode_en |=> mode_en);

    p_rsten_sticky_r6: assert property (@(posedge bus_clk) disable iff (!rst_n)
        mode_rsten |=> mode_rsten);

    p_expiry_flags_r7: assert property (@(posedge bus_clk) disable iff (!rst_n)
        uf_evt |=> (wd_irq_o && mode_tof));

    p_reset_hold_r8: assert property (@(posedge bus_clk) disable iff (!rst_n)
        wd_reset_o |=> wd_reset_o);

    p_feed_clears_irq_r10: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (feed_ok && !uf_evt) |=> !wd_irq_o);

    p_count_upper_zero_r11: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == 2'd3) |-> (bus_rdata[DATA_W-1:CNT_W] == '0));
endmodule

bind wdt_feed_guard wdt_feed_guard_chk #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .MIN_RELOAD(MIN_RELOAD)
) u_chk (
    .bus_clk(bus_clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .feed_ok(feed_ok),
    .feed_err(feed_err), .en_active(en_active), .mode_en(mode_en),
    .mode_rsten(mode_rsten), .mode_tof(mode_tof), .uf_evt(uf_evt),
    .reload_q(reload_q), .wd_irq_o(wd_irq_o), .wd_reset_o(wd_reset_o)
);

// File: tb/wdt_feed_guard_tb.sv
`timescale 1ns/1ps
module wdt_feed_guard_tb;
    logic        bus_clk = 1'b0;
    logic        wd_clk  = 1'b0;
    logic        rst_n   = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr  = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_irq_o, wd_reset_o;

    int n_checks = 0;
    int n_errs   = 0;

    always #10 bus_clk = !bus_clk;
    always #7  wd_clk  = !wd_clk;

    wdt_feed_guard u_dut (
        .bus_clk(bus_clk), .wd_clk(wd_clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wd_irq_o(wd_irq_o), .wd_reset_o(wd_reset_o)
    );

    // {write data, expected readback} for the reload register (R2)
    localparam logic [63:0] RELOAD_VEC [8] = '{
        {32'h0000_0010, 32'h0000_00FF},
        {32'h0000_0000, 32'h0000_00FF},
        {32'h0000_00FE, 32'h0000_00FF},
        {32'h0000_0100, 32'h0000_0100},
        {32'hFFFF_FFFF, 32'h00FF_FFFF},
        {32'h1234_5678, 32'h0034_5678},
        {32'hAB00_0005, 32'h0000_00FF},
        {32'h0000_00FF, 32'h0000_00FF}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge bus_clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge bus_clk);
        #1 bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge bus_clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge bus_clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge bus_clk);
    endtask

    task automatic feed();
        bus_write(2'd2, 32'h0000_00AA);
        bus_write(2'd2, 32'h0000_0055);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic run_tests();
        logic [31:0] rd;
        do_reset();
        // R1 reset state
        bus_read(2'd0, rd); check(rd == 32'h0, "R1 ctrl", rd, 32'h0);
        bus_read(2'd1, rd); check(rd == 32'hFF, "R1 reload", rd, 32'hFF);
        bus_read(2'd3, rd); check(rd == 32'hFF, "R1 count", rd, 32'hFF);
        check(!wd_irq_o && !wd_reset_o, "R1 outputs", {30'b0, wd_irq_o, wd_reset_o}, 32'h0);

        // R2 table walk
        for (int i = 0; i < 8; i++) begin
            bus_write(2'd1, RELOAD_VEC[i][63:32]);
            bus_read(2'd1, rd);
            check(rd == RELOAD_VEC[i][31:0], "R2 reload floor", rd, RELOAD_VEC[i][31:0]);
        end

        // R5 enable set, no service: counter frozen
        bus_write(2'd0, 32'h1);
        wait_cyc(300);
        bus_read(2'd3, rd); check(rd == 32'hFF, "R5 frozen before service", rd, 32'hFF);

        // R3 valid service then R7 rate
        feed();
        wait_cyc(20);
        bus_read(2'd3, rd); check(rd <= 32'hFF && rd >= 32'hF0, "R3 reloaded near 0xFF", rd, 32'hFF);
        wait_cyc(100);
        bus_read(2'd3, rd);
        check(rd >= 32'hCD && rd <= 32'hE1, "R7 divide-by-4 rate", rd, 32'hD7);
        check(rd[31:24] == 8'h0, "R11 upper count bits", rd, {8'h0, rd[23:0]});
        wait_cyc(520);
        check(!wd_irq_o, "R7 no early expiry", {31'b0, wd_irq_o}, 32'h0);
        wait_cyc(100);
        check(wd_irq_o, "R7 expiry irq", {31'b0, wd_irq_o}, 32'h1);
        bus_read(2'd0, rd); check(rd == 32'hD, "R7 flags set", rd, 32'hD);
        check(!wd_reset_o, "R8 no reset without enable bit", {31'b0, wd_reset_o}, 32'h0);

        // R9 / R6
        bus_write(2'd0, 32'h4);
        bus_read(2'd0, rd); check(rd == 32'hD, "R9 write 1 to tof no effect, R6 en kept", rd, 32'hD);
        bus_write(2'd0, 32'h0);
        bus_read(2'd0, rd); check(rd == 32'h9, "R9 tof cleared by 0, R6 en kept", rd, 32'h9);

        // R10 service clears interrupt
        feed();
        wait_cyc(2);
        check(!wd_irq_o, "R10 irq cleared", {31'b0, wd_irq_o}, 32'h0);
        bus_read(2'd0, rd); check(rd == 32'h1, "R10 int flag cleared", rd, 32'h1);

        // R4 abort by interposed read
        wait_cyc(300);
        bus_write(2'd2, 32'h0000_00AA);
        bus_read(2'd1, rd);
        bus_write(2'd2, 32'h0000_0055);
        wait_cyc(30);
        bus_read(2'd3, rd); check(rd < 32'hC0, "R4 read abort no reload", rd, 32'hA0);
        bus_read(2'd0, rd); check(rd == 32'h5, "R4 error sets tof only", rd, 32'h5);
        check(!wd_reset_o && !wd_irq_o, "R4 no reset/irq", {30'b0, wd_irq_o, wd_reset_o}, 32'h0);

        // R4 abort by wrong byte
        bus_write(2'd0, 32'h0);
        bus_write(2'd2, 32'h0000_00AA);
        bus_write(2'd2, 32'h0000_0056);
        bus_write(2'd2, 32'h0000_0055);
        wait_cyc(30);
        bus_read(2'd3, rd); check(rd < 32'hC0, "R4 wrong byte no reload", rd, 32'hA0);
        bus_read(2'd0, rd); check(rd == 32'h5, "R4 wrong byte sets tof", rd, 32'h5);

        // R12 upper service bits ignored
        bus_write(2'd2, 32'hFFFF_FFAA);
        bus_write(2'd2, 32'hABCD_1255);
        wait_cyc(20);
        bus_read(2'd3, rd); check(rd >= 32'hF0 && rd <= 32'hFF, "R12 service with upper bits", rd, 32'hFF);

        // R4 error with reset-enable drives reset; R6 rsten sticky
        bus_write(2'd0, 32'h3);
        bus_write(2'd2, 32'h0000_00AA);
        bus_write(2'd0, 32'h0);
        wait_cyc(3);
        check(wd_reset_o, "R4 error reset", {31'b0, wd_reset_o}, 32'h1);
        bus_read(2'd0, rd); check(rd[1:0] == 2'b11, "R6 en/rsten not clearable", rd, 32'h7);

        // R8 expiry reset, sticky
        do_reset();
        check(!wd_reset_o, "R1 reset clears reset out", {31'b0, wd_reset_o}, 32'h0);
        bus_read(2'd0, rd); check(rd == 32'h0, "R1 ctrl after reset", rd, 32'h0);
        bus_write(2'd0, 32'h3);
        feed();
        wait_cyc(800);
        check(wd_reset_o && wd_irq_o, "R8 expiry reset", {30'b0, wd_irq_o, wd_reset_o}, 32'h3);
        bus_write(2'd0, 32'h0);
        feed();
        wait_cyc(5);
        check(wd_reset_o, "R8 reset sticky", {31'b0, wd_reset_o}, 32'h1);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (200000) @(posedge bus_clk);
                check(1'b0, "watchdog timeout", 32'h0, 32'h1);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule